// File: doc/BRIEF.md
# Compare-and-Exchange Execution Unit

This unit performs a conditional swap between a destination operand and the accumulator. The operand can be 8, 16 or 32 bits wide. The caller gives it the opcode byte that follows the two-byte escape, an operand-size override flag and the accumulator. It also supplies a source register value and either a register destination value or a memory word address. The unit compares the destination with the accumulator, using only the bits that the operand size covers. On a match it writes the source into the destination and sets the zero flag. On a mismatch it leaves the destination alone, copies the destination into the accumulator and clears the zero flag.

A register destination completes in one clock. A memory destination runs a short bus sequence: read, compare, then a write only on a match. When the caller asks for atomicity, the unit first requests the bus lock and waits for its grant. It keeps the lock through the last access and drops it before it reports completion. Each result is presented for exactly one cycle, together with write strobes for the accumulator, the register destination and the zero flag.

Top module: `cmpxchg_unit`

## Requirements
- R1: Opcode 0xB0 and its alias 0xA6 select the 8-bit form. Opcode 0xB1 and its alias 0xA7 select the 32-bit form when `size_ovr_i`=0 and the 16-bit form when `size_ovr_i`=1. Each alias gives the same results as its primary opcode.
- R2: The compare covers only the low 8, 16 or 32 bits that the operand size selects. Differences above that slice do not affect the outcome.
- R3: On a match the unit writes the source slice into the destination, sets the zero flag (`zf_o`=1 with `zf_we_o`=1) and does not write the accumulator (`acc_we_o`=0).
- R4: On a mismatch the unit copies the destination slice into the accumulator (`acc_we_o`=1), clears the zero flag (`zf_o`=0 with `zf_we_o`=1) and does not write the destination.
- R5: On an 8-bit or 16-bit result, the accumulator bits and destination bits above the operand size keep their previous values.
- R6: An opcode outside {0xB0, 0xB1, 0xA6, 0xA7} raises `illegal_o` in the completion cycle. No write strobe is asserted, no bus cycle is made and memory is unchanged.
- R7: A register destination (`dst_mem_i`=0) raises `done_o` in the cycle after the start. It makes no bus access and never requests the lock, even when `lock_i`=1.
- R8: For a memory destination with `lock_i`=1, no bus read or write occurs unless the lock is both requested and granted. The request stays high without a gap from the read through the last access, and it is low when `done_o` is high.
- R9: A mismatch on a memory destination makes no bus write cycle. A match makes exactly one bus write, which carries the merged value.
- R10: `done_o` is high for exactly one cycle per operation. A start that arrives while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation; sampled only while idle |
| opcode_i | input | 8 | Opcode byte following the escape |
| size_ovr_i | input | 1 | Operand-size override: 1 selects 16-bit for the wide opcodes |
| dst_mem_i | input | 1 | 1: destination is memory, 0: register |
| lock_i | input | 1 | Perform the memory sequence under the bus lock |
| acc_i | input | DW | Accumulator value |
| src_i | input | DW | Source register value |
| dst_reg_i | input | DW | Register destination value |
| addr_i | input | AW | Memory destination word address |
| bus_lock_req_o | output | 1 | Bus lock request |
| bus_lock_gnt_i | input | 1 | Bus lock grant |
| bus_rd_o | output | 1 | Read request, held until acknowledged |
| bus_wr_o | output | 1 | Write request, held until acknowledged |
| bus_addr_o | output | AW | Bus word address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Opcode not recognised (valid with done) |
| acc_o | output | DW | New accumulator value |
| acc_we_o | output | 1 | Accumulator write strobe |
| dst_reg_o | output | DW | New register destination value |
| dst_reg_we_o | output | 1 | Register destination write strobe |
| zf_o | output | 1 | Zero flag value |
| zf_we_o | output | 1 | Zero flag write strobe |

## Verification
The bench uses the default 32-bit data width and sets a 4-bit address, which gives a 16-word model memory whose contents are known from reset. With 32-bit data, all three operand sizes can be exercised, including slices that match while the upper bits differ. The memory model grants the lock two cycles late and acknowledges each access one cycle late. That delay makes the waits for grant and acknowledge visible, and it leaves room to send a second start while the unit is busy.

// File: rtl/cx_pkg.sv
package cx_pkg;
  typedef enum logic [1:0] {SZ_B, SZ_W, SZ_D} size_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOCK, ST_READ, ST_CMP, ST_WRITE, ST_REL, ST_DONE
  } state_e;
endpackage

// File: rtl/cx_decode.sv
module cx_decode
  import cx_pkg::*;
#(
  parameter logic [7:0] OP_NARROW = 8'hB0,
  parameter logic [7:0] OP_WIDE   = 8'hB1,
  parameter logic [7:0] ALT_NARROW = 8'hA6,
  parameter logic [7:0] ALT_WIDE   = 8'hA7
) (
  input  logic [7:0] opcode_i,
  input  logic       size_ovr_i,
  output logic       legal_o,
  output size_e      size_o
);
  logic narrow, wide;
  assign narrow  = (opcode_i == OP_NARROW) || (opcode_i == ALT_NARROW);
  assign wide    = (opcode_i == OP_WIDE)   || (opcode_i == ALT_WIDE);
  assign legal_o = narrow || wide;

  always_comb begin
    if (narrow)          size_o = SZ_B;
    else if (size_ovr_i) size_o = SZ_W;
    else                 size_o = SZ_D;
  end
endmodule

// File: rtl/cx_alu.sv
module cx_alu
  import cx_pkg::*;
#(
  parameter int DW = 32
) (
  input  size_e          size_i,
  input  logic [DW-1:0]  acc_i,
  input  logic [DW-1:0]  src_i,
  input  logic [DW-1:0]  dst_i,
  output logic           eq_o,
  output logic [DW-1:0]  dst_new_o,
  output logic [DW-1:0]  acc_new_o
);
  localparam int BW = 8;
  localparam int WW = (DW < 16) ? DW : 16;

  logic [DW-1:0] mask;
  always_comb begin
    mask = '1;
    unique case (size_i)
      SZ_B:    mask = {{(DW-BW){1'b0}}, {BW{1'b1}}};
      SZ_W:    mask = {{(DW-WW){1'b0}}, {WW{1'b1}}};
      default: mask = '1;
    endcase
  end

  assign eq_o      = ((dst_i ^ acc_i) & mask) == '0;
  assign dst_new_o = (dst_i & ~mask) | (src_i & mask);
  assign acc_new_o = (acc_i & ~mask) | (dst_i & mask);
endmodule

// File: rtl/cx_seq.sv
module cx_seq
  import cx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   legal_i,
  input  logic   dst_mem_i,
  input  logic   lock_i,
  input  logic   lock_q_i,
  input  logic   eq_i,
  input  logic   gnt_i,
  input  logic   ack_i,
  output logic   cap_o,
  output logic   rcap_o,
  output logic   lock_req_o,
  output logic   rd_o,
  output logic   wr_o,
  output logic   done_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:
        if (start_i) begin
          if (!legal_i || !dst_mem_i) state_d = ST_DONE;
          else if (lock_i)            state_d = ST_LOCK;
          else                        state_d = ST_READ;
        end
      ST_LOCK:  if (gnt_i) state_d = ST_READ;
      ST_READ:  if (ack_i) state_d = ST_CMP;
      ST_CMP:   state_d = eq_i ? ST_WRITE : ST_REL;
      ST_WRITE: if (ack_i) state_d = ST_REL;
      ST_REL:   state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;

  assign cap_o  = (state_q == ST_IDLE) && start_i;
  assign rcap_o = (state_q == ST_READ) && ack_i;
  assign rd_o   = (state_q == ST_READ);
  assign wr_o   = (state_q == ST_WRITE);
  assign done_o = (state_q == ST_DONE);
  assign lock_req_o = lock_q_i &&
    ((state_q == ST_LOCK) || (state_q == ST_READ) ||
     (state_q == ST_CMP)  || (state_q == ST_WRITE));

  // R8: locked accesses only under grant
  a_r8_access_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) && lock_q_i |-> gnt_i && lock_req_o);
  // R9: write only after a match
  a_r9_write_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> eq_i);
  // R10: one-cycle completion
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7: register destination done next cycle, no lock
  a_r7_reg_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o && !dst_mem_i |=> done_o && !lock_req_o && !rd_o);
endmodule

// File: rtl/cmpxchg_unit.sv
module cmpxchg_unit
  import cx_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic          size_ovr_i,
  input  logic          dst_mem_i,
  input  logic          lock_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_reg_i,
  input  logic [AW-1:0] addr_i,
  output logic          bus_lock_req_o,
  input  logic          bus_lock_gnt_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  output logic          done_o,
  output logic          illegal_o,
  output logic [DW-1:0] acc_o,
  output logic          acc_we_o,
  output logic [DW-1:0] dst_reg_o,
  output logic          dst_reg_we_o,
  output logic          zf_o,
  output logic          zf_we_o
);
  logic          legal_d, cap, rcap, eq;
  size_e         size_d, size_q;
  logic          legal_q, mem_q, lock_q;
  logic [DW-1:0] acc_q, src_q, dreg_q, rdat_q, dst_cur, dst_new, acc_new;
  logic [AW-1:0] addr_q;

  cx_decode u_dec (
    .opcode_i  (opcode_i),
    .size_ovr_i(size_ovr_i),
    .legal_o   (legal_d),
    .size_o    (size_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      size_q  <= SZ_B;
      legal_q <= 1'b0;
      mem_q   <= 1'b0;
      lock_q  <= 1'b0;
      acc_q   <= '0;
      src_q   <= '0;
      dreg_q  <= '0;
      addr_q  <= '0;
    end else if (cap) begin
      size_q  <= size_d;
      legal_q <= legal_d;
      mem_q   <= dst_mem_i;
      lock_q  <= lock_i && dst_mem_i && legal_d;
      acc_q   <= acc_i;
      src_q   <= src_i;
      dreg_q  <= dst_reg_i;
      addr_q  <= addr_i;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)   rdat_q <= '0;
    else if (rcap) rdat_q <= bus_rdata_i;

  assign dst_cur = mem_q ? rdat_q : dreg_q;

  cx_alu #(.DW(DW)) u_alu (
    .size_i   (size_q),
    .acc_i    (acc_q),
    .src_i    (src_q),
    .dst_i    (dst_cur),
    .eq_o     (eq),
    .dst_new_o(dst_new),
    .acc_new_o(acc_new)
  );

  cx_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .legal_i   (legal_d),
    .dst_mem_i (dst_mem_i),
    .lock_i    (lock_i),
    .lock_q_i  (lock_q),
    .eq_i      (eq),
    .gnt_i     (bus_lock_gnt_i),
    .ack_i     (bus_ack_i),
    .cap_o     (cap),
    .rcap_o    (rcap),
    .lock_req_o(bus_lock_req_o),
    .rd_o      (bus_rd_o),
    .wr_o      (bus_wr_o),
    .done_o    (done_o)
  );

  assign bus_addr_o   = addr_q;
  assign bus_wdata_o  = dst_new;
  assign illegal_o    = done_o && !legal_q;
  assign zf_o         = eq;
  assign zf_we_o      = done_o && legal_q;
  assign acc_o        = acc_new;
  assign acc_we_o     = done_o && legal_q && !eq;
  assign dst_reg_o    = dst_new;
  assign dst_reg_we_o = done_o && legal_q && !mem_q && eq;

  // R6: illegal opcode writes nothing
  a_r6_illegal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !acc_we_o && !dst_reg_we_o && !zf_we_o);
  // R4: mismatch clears the flag and leaves the destination
  a_r4_mismatch_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o |-> !zf_o && !dst_reg_we_o);
  // R5: upper accumulator bits kept on byte results
  a_r5_acc_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_we_o && (size_q == SZ_B) |-> acc_o[DW-1:8] == acc_q[DW-1:8]);
  // R8: lock dropped before completion
  a_r8_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_lock_req_o);
endmodule

// File: tb/sim_cmpxchg_unit.sv
module sim_cmpxchg_unit;
  localparam int DW = 32;
  localparam int AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 0, ovr = 0, dmem = 0, lck = 0;
  logic [7:0] opc = 0;
  logic [DW-1:0] acc = 0, src = 0, dreg = 0;
  logic [AW-1:0] addr = 0;
  logic lreq, gnt, rd, wr, ack, done, ill, accwe, dwe, zf, zfwe;
  logic [AW-1:0] baddr;
  logic [DW-1:0] wdata, rdata, acco, dsto;

  cmpxchg_unit #(.DW(DW), .AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opc),
    .size_ovr_i(ovr), .dst_mem_i(dmem), .lock_i(lck), .acc_i(acc),
    .src_i(src), .dst_reg_i(dreg), .addr_i(addr),
    .bus_lock_req_o(lreq), .bus_lock_gnt_i(gnt), .bus_rd_o(rd),
    .bus_wr_o(wr), .bus_addr_o(baddr), .bus_wdata_o(wdata),
    .bus_rdata_i(rdata), .bus_ack_i(ack), .done_o(done),
    .illegal_o(ill), .acc_o(acco), .acc_we_o(accwe), .dst_reg_o(dsto),
    .dst_reg_we_o(dwe), .zf_o(zf), .zf_we_o(zfwe));

  // memory and lock arbiter model
  logic [DW-1:0] mem [16];
  logic gdly;
  int   cyc;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 32'h1020_3040 + i * 32'h0101_0101;
      gnt <= 0; gdly <= 0; ack <= 0; rdata <= 0; cyc <= 0;
    end else begin
      cyc  <= cyc + 1;
      gdly <= lreq;
      gnt  <= lreq && gdly;
      ack  <= (rd || wr) && !ack;
      if (rd && !ack) rdata <= mem[baddr];
      if (wr && !ack) mem[baddr] <= wdata;
    end

  typedef struct {
    logic          illegal, zf, accwe, dwe, is_mem;
    logic [DW-1:0] acc, dst;
    logic [AW-1:0] addr;
    int            wrs, lat;
    string         tag;
  } item_t;
  item_t q[$];

  int tests = 0, fails = 0;
  logic cur_reg = 0, cur_lock = 0, cur_bus = 0;
  int st_cyc = 0;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor
  int viol = 0, wrs = 0;
  logic seen_lock = 0, dropped = 0;
  always @(negedge clk) if (rst_n) begin
    if (cur_reg && (lreq || rd || wr)) viol++;
    if (!cur_bus && (rd || wr)) viol++;
    if (cur_lock && (rd || wr) && !(gnt && lreq)) viol++;
    if (lreq) seen_lock = 1;
    else if (seen_lock) dropped = 1;
    if (dropped && (rd || wr)) viol++;
    if (wr && ack) wrs++;
    if (done) begin
      if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
      else begin
        item_t e;
        e = q.pop_front();
        chk(ill == e.illegal, e.tag, "illegal", ill, e.illegal);
        chk(zfwe == !e.illegal, e.tag, "zf_we", zfwe, !e.illegal);
        chk(accwe == e.accwe, e.tag, "acc_we", accwe, e.accwe);
        chk(dwe == e.dwe, e.tag, "dst_we", dwe, e.dwe);
        if (!e.illegal) chk(zf == e.zf, e.tag, "zf", zf, e.zf);
        if (e.accwe) chk(acco == e.acc, e.tag, "acc", acco, e.acc);
        if (e.dwe) chk(dsto == e.dst, e.tag, "dst_reg", dsto, e.dst);
        if (e.is_mem) chk(mem[e.addr] == e.dst, e.tag, "mem", mem[e.addr], e.dst);
        chk(wrs == e.wrs, e.tag, "write count", wrs, e.wrs);
        chk(viol == 0, e.tag, "bus protocol violations", viol, 0);
        chk(!lreq, "R8", "lock at done", lreq, 0);
        if (e.lat >= 0) chk(cyc - st_cyc == e.lat, "R7", "latency", cyc - st_cyc, e.lat);
      end
      viol = 0; wrs = 0; seen_lock = 0; dropped = 0;
    end
  end

  // model from requirements
  task automatic run(input string tag, input logic [7:0] op, input logic ov,
                     input logic m, input logic lk, input logic [DW-1:0] a,
                     input logic [DW-1:0] s, input logic [DW-1:0] d,
                     input logic [AW-1:0] ad, input logic extra);
    item_t e;
    logic [DW-1:0] msk, dv;
    logic legal, eqv;
    legal = (op == 8'hB0) || (op == 8'hA6) || (op == 8'hB1) || (op == 8'hA7);
    msk = ((op == 8'hB0) || (op == 8'hA6)) ? 32'hFF : (ov ? 32'hFFFF : 32'hFFFF_FFFF);
    dv  = m ? mem[ad] : d;
    eqv = ((dv & msk) == (a & msk));
    e.tag = tag; e.illegal = !legal; e.is_mem = m; e.addr = ad;
    e.zf = eqv;
    e.accwe = legal && !eqv;
    e.dwe = legal && !m && eqv;
    e.acc = (a & ~msk) | (dv & msk);
    e.dst = (legal && eqv) ? ((dv & ~msk) | (s & msk)) : dv;
    e.wrs = (legal && m && eqv) ? 1 : 0;
    e.lat = (!m || !legal) ? 1 : -1;
    q.push_back(e);
    cur_reg = !m; cur_bus = m && legal; cur_lock = m && legal && lk;
    @(negedge clk);
    opc = op; ovr = ov; dmem = m; lck = lk; acc = a; src = s; dreg = d;
    addr = ad; start = 1; st_cyc = cyc;
    @(negedge clk);
    start = 0;
    if (extra) begin
      @(negedge clk);
      opc = 8'hB1; ovr = 0; acc = 32'hDEAD_BEEF; src = 32'h0BAD_F00D;
      dmem = 0; start = 1;   // R10: ignored while busy
      @(negedge clk);
      start = 0;
    end
    while (q.size() != 0) @(negedge clk);
    cur_reg = 0; cur_bus = 0; cur_lock = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !lreq && !rd && !wr, "R10", "reset quiet",
        {done, lreq, rd, wr}, 0);
    rst_n = 1;
    @(negedge clk);
    run("R3", 8'hB0, 0, 0, 0, 32'h1111_2233, 32'hCCCC_DD44, 32'hAAAA_BB33, 0, 0);
    run("R1", 8'hA6, 0, 0, 0, 32'h1111_2233, 32'hCCCC_DD44, 32'hAAAA_BB33, 0, 0);
    run("R5", 8'hB1, 1, 0, 0, 32'h1234_5678, 32'h0, 32'h9999_5679, 0, 0);
    run("R1", 8'hA7, 0, 0, 0, 32'h5555_AAAA, 32'h0123_4567, 32'h5555_AAAA, 0, 0);
    run("R4", 8'hB1, 0, 0, 0, 32'h0000_00FF, 32'h7, 32'h0100_00FF, 0, 0);
    run("R2", 8'hB1, 1, 0, 0, 32'hFFFF_1234, 32'hABCD_9876, 32'h0000_1234, 0, 0);
    run("R6", 8'hB2, 0, 0, 0, 32'h1, 32'h2, 32'h1, 0, 0);
    run("R6", 8'h0F, 0, 1, 1, mem[3], 32'h77, 0, 3, 0);
    run("R7", 8'hB1, 0, 0, 1, 32'h42, 32'h43, 32'h42, 0, 0);
    run("R8", 8'hB1, 0, 1, 1, mem[5], 32'hCAFE_0005, 0, 5, 0);
    run("R9", 8'hB1, 0, 1, 1, 32'h0, 32'hCAFE_0006, 0, 6, 0);
    run("R5", 8'hB0, 0, 1, 0, {24'h0, mem[7][7:0]}, 32'hFFFF_FF99, 0, 7, 0);
    run("R1", 8'hA7, 1, 1, 1, {16'hFFFF, mem[9][15:0]}, 32'h1357_2468, 0, 9, 0);
    run("R10", 8'hB1, 0, 1, 1, mem[11], 32'h600D_000B, 0, 11, 1);
    run("R4", 8'hA6, 0, 1, 0, 32'h0, 32'h55, 0, 12, 0);
    repeat (4) @(negedge clk);
    chk(q.size() == 0 && !done, "R10", "no stray completion", done, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule